// File: doc/BRIEF.md
# Segmented Multi-Path Pseudonoise Chip Generator

This block feeds the switch mixers of a parallel compressive-sampling front end with one pseudonoise chip stream per path. The chip streams are cut from a single maximal-length 11-bit shift-register sequence of 2047 chips. Each path is given its own contiguous segment of `SEG_LEN` chips, and no two segments overlap. Every path replays its segment from the beginning once per measurement period, and all paths restart on the same tick, so the mixer codes stay aligned with the integration windows.

After reset, a single walker register steps through the base sequence. It records where each segment begins and raises `ready_o` when every start state is known. Software or a sequencer then pulses `resync_i` to begin playback. After that, each clock on which `chip_en_i` is high advances all paths by one chip. The chip following the last one in a segment reloads every path with its start state and emits `period_o`.

Top module: `pnseg_chipgen`

## Requirements
- R1: While reset is applied and until the first accepted resync, every `chip_o` bit reads 1 (each path register holds the all-ones seed), `period_o` reads 0, and `ready_o` reads 0 until the walk completes.
- R2: `ready_o` rises on exactly the `(NUM_PATHS-1)*SEG_LEN`-th clock edge after reset is released, which is the 1500th edge at default parameters. It then stays high until the next reset.
- R3: A `resync_i` seen while `ready_o` is low is ignored. The chips keep their value and no `period_o` pulse appears.
- R4: `chip_en_i` has no effect before the first accepted resync. The chips keep their value.
- R5: The base sequence b obeys b[0..10] = 1 and b[n+11] = b[n] XOR b[n+2]. While playing, path k outputs b[k*SEG_LEN + i] on `chip_o[k]`, where i is the chip index within the period. Bit 1 stands for +1 and bit 0 for −1.
- R6: On a clock edge where `ready_o` and `resync_i` are both high, every path moves to chip index 0 and `period_o` is high for the following cycle. This happens whatever the value of `chip_en_i`.
- R7: While playing and with no resync, each edge with `chip_en_i` high advances the chip index by one. The enable edge after index `SEG_LEN-1` returns every path to index 0 and raises `period_o` for one cycle.
- R8: On an edge with both `chip_en_i` and `resync_i` low, `chip_o` keeps its value and `period_o` is low in the next cycle.
- R9: No path register ever holds the all-zero state.
- R10: When a resync and a segment wrap fall on the same edge, exactly one restart happens: index 0 is shown and `period_o` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en_i | input | 1 | Chip tick; advances all paths by one chip |
| resync_i | input | 1 | Restart all paths at chip index 0 (once ready) |
| chip_o | output | NUM_PATHS | Current chip of each path, 1 = +1, 0 = −1 |
| period_o | output | 1 | One-cycle pulse in the first cycle of each period |
| ready_o | output | 1 | Segment start states are available |

## Verification
The situation hardest to reach from the ports is the far end of the last segment. This is base index 1999 on path 3, which only appears after a full 500-enable run. Close behind it is a resync landing on the very edge where a wrap is due. The stimulus runs whole periods under both a dense and a sparse enable pattern. It polls the bench model's chip index so that it can raise resync and the enable together on the last chip of a period. It also holds resync across the edge where `ready_o` rises, and it applies a reset in the middle of playback so that the walk and the resync gate are exercised a second time.

// File: rtl/pnseg_pkg.sv
package pnseg_pkg;
  // Base shift register: x^11 + x^9 + 1, Fibonacci form, shifting toward the MSB.
  localparam int LFSR_W = 11;
  localparam int TAP_HI = LFSR_W - 1;
  localparam int TAP_LO = 8;
  localparam logic [LFSR_W-1:0] SEED = '1;

  typedef logic [LFSR_W-1:0] lfsr_t;

  function automatic lfsr_t lfsr_next(input lfsr_t s);
    return {s[LFSR_W-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  // The chip presented by a state is its MSB: the oldest bit in the register.
  function automatic logic chip_of(input lfsr_t s);
    return s[LFSR_W-1];
  endfunction
endpackage

// File: rtl/pnseg_start_table.sv
module pnseg_start_table
  import pnseg_pkg::*;
#(
  parameter int NUM_PATHS = 4,
  parameter int SEG_LEN   = 500
) (
  input  logic  clk,
  input  logic  rst_n,
  output lfsr_t start_o [NUM_PATHS],
  output logic  ready_o
);
  localparam int WALK_LEN = (NUM_PATHS - 1) * SEG_LEN;
  localparam int CW       = $clog2(WALK_LEN + 2);

  lfsr_t           walk_q;
  logic [CW-1:0]   cnt_q;
  logic            ready_q;
  lfsr_t           walk_nxt;
  logic [CW-1:0]   cnt_nxt;

  assign walk_nxt = lfsr_next(walk_q);
  assign cnt_nxt  = cnt_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walk_q  <= SEED;
      cnt_q   <= '0;
      ready_q <= (WALK_LEN == 0);
    end else if (!ready_q) begin
      walk_q <= walk_nxt;
      cnt_q  <= cnt_nxt;
      if (cnt_nxt == CW'(WALK_LEN)) ready_q <= 1'b1;
    end
  end

  assign start_o[0] = SEED;

  for (genvar k = 1; k < NUM_PATHS; k++) begin : g_cap
    lfsr_t cap_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        cap_q <= SEED;
      else if (!ready_q && cnt_nxt == CW'(k * SEG_LEN))
        cap_q <= walk_nxt;
    end
    assign start_o[k] = cap_q;
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/pnseg_path.sv
module pnseg_path
  import pnseg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  logic  step_i,
  input  lfsr_t start_i,
  output lfsr_t state_o,
  output logic  chip_o
);
  lfsr_t state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= SEED;
    else if (load_i) state_q <= start_i;
    else if (step_i) state_q <= lfsr_next(state_q);
  end

  assign state_o = state_q;
  assign chip_o  = chip_of(state_q);
endmodule

// File: rtl/pnseg_period.sv
module pnseg_period #(
  parameter int SEG_LEN = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_i,
  input  logic resync_i,
  input  logic chip_en_i,
  output logic load_o,
  output logic step_o,
  output logic wrap_o,
  output logic period_o
);
  localparam int IW = $clog2(SEG_LEN + 1);

  logic [IW-1:0] idx_q;
  logic          running_q;
  logic          pulse_q;
  logic          start_evt;

  assign start_evt = ready_i && resync_i;
  assign wrap_o    = running_q && chip_en_i && !start_evt && (idx_q == IW'(SEG_LEN - 1));
  assign load_o    = start_evt || wrap_o;
  assign step_o    = running_q && chip_en_i && !load_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      running_q <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      pulse_q <= load_o;
      if (start_evt) running_q <= 1'b1;
      if (load_o)      idx_q <= '0;
      else if (step_o) idx_q <= idx_q + IW'(1);
    end
  end

  assign period_o = pulse_q;
endmodule

// File: rtl/pnseg_chipgen.sv
module pnseg_chipgen
  import pnseg_pkg::*;
#(
  parameter int NUM_PATHS = 4,
  parameter int SEG_LEN   = 500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 chip_en_i,
  input  logic                 resync_i,
  output logic [NUM_PATHS-1:0] chip_o,
  output logic                 period_o,
  output logic                 ready_o
);
  lfsr_t start_tab [NUM_PATHS];
  lfsr_t path_state [NUM_PATHS];
  logic  load;
  logic  step;
  logic  wrap_evt;
  logic  zero_state;

  pnseg_start_table #(.NUM_PATHS(NUM_PATHS), .SEG_LEN(SEG_LEN)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_o (start_tab),
    .ready_o (ready_o)
  );

  pnseg_period #(.SEG_LEN(SEG_LEN)) u_period (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready_i   (ready_o),
    .resync_i  (resync_i),
    .chip_en_i (chip_en_i),
    .load_o    (load),
    .step_o    (step),
    .wrap_o    (wrap_evt),
    .period_o  (period_o)
  );

  for (genvar k = 0; k < NUM_PATHS; k++) begin : g_path
    pnseg_path u_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (load),
      .step_i  (step),
      .start_i (start_tab[k]),
      .state_o (path_state[k]),
      .chip_o  (chip_o[k])
    );
  end

  // Named event for the checker: some path register reads all zeros.
  always_comb begin
    zero_state = 1'b0;
    for (int k = 0; k < NUM_PATHS; k++)
      if (path_state[k] == '0) zero_state = 1'b1;
  end
endmodule

// File: rtl/pnseg_chipgen_chk.sv
module pnseg_chipgen_chk #(
  parameter int NUM_PATHS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 chip_en_i,
  input logic                 resync_i,
  input logic [NUM_PATHS-1:0] chip_o,
  input logic                 period_o,
  input logic                 ready_o,
  input logic                 zero_state,
  input logic                 wrap_evt
);
  assert_ready_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> ready_o);

  assert_no_pulse_unready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_o |-> ready_o);

  assert_resync_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && resync_i) |=> period_o);

  assert_wrap_pulses_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> period_o);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_en_i && !resync_i) |=> ($stable(chip_o) && !period_o));

  assert_never_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !zero_state);

  assert_single_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && resync_i) |-> !wrap_evt);
endmodule

bind pnseg_chipgen pnseg_chipgen_chk #(.NUM_PATHS(NUM_PATHS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chip_en_i  (chip_en_i),
  .resync_i   (resync_i),
  .chip_o     (chip_o),
  .period_o   (period_o),
  .ready_o    (ready_o),
  .zero_state (zero_state),
  .wrap_evt   (wrap_evt)
);

// File: tb/pnseg_chipgen_test.sv
module pnseg_chipgen_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int SL         = 500;
  localparam int WALK       = (NP - 1) * SL;
  localparam int SEQ_LEN    = 2047;
  localparam int WATCHDOG   = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en_i = 1'b0;
  logic          resync_i = 1'b0;
  logic [NP-1:0] chip_o;
  logic          period_o;
  logic          ready_o;

  pnseg_chipgen #(.NUM_PATHS(NP), .SEG_LEN(SL)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en_i (chip_en_i),
    .resync_i  (resync_i),
    .chip_o    (chip_o),
    .period_o  (period_o),
    .ready_o   (ready_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  bit    seq [SEQ_LEN];
  int    vectors = 0;
  int    miscompares = 0;
  int    cyc = 0;
  bit    checking = 0;
  bit    done = 0;
  string phase_tag = "R1";

  // Behavioural reference: counts clocks and chip positions only.
  int m_clks = 0;
  bit m_running = 0;
  int m_idx = 0;
  bit m_pulse = 0;
  bit m_ready = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clks = 0; m_running = 0; m_idx = 0; m_pulse = 0; m_ready = 0;
    end else begin
      m_pulse = 0;
      if (m_ready && resync_i) begin
        m_running = 1; m_idx = 0; m_pulse = 1;
      end else if (m_running && chip_en_i) begin
        if (m_idx == SL - 1) begin m_idx = 0; m_pulse = 1; end
        else m_idx = m_idx + 1;
      end
      m_clks = m_clks + 1;
      if (m_clks >= WALK) m_ready = 1;
    end
  end

  function automatic logic [NP-1:0] exp_chips();
    logic [NP-1:0] v;
    for (int k = 0; k < NP; k++) v[k] = m_running ? seq[k * SL + m_idx] : 1'b1;
    return v;
  endfunction

  always @(negedge clk) begin
    if (checking && !done) begin
      vectors++;
      if (chip_o !== exp_chips()) begin
        miscompares++;
        $display("FAIL %s/R5 chips at idx %0d: got %b exp %b", phase_tag, m_idx, chip_o, exp_chips());
      end
      vectors++;
      if (period_o !== m_pulse) begin
        miscompares++;
        $display("FAIL %s/R6/R7 period pulse: got %b exp %b", phase_tag, period_o, m_pulse);
      end
      vectors++;
      if (ready_o !== m_ready) begin
        miscompares++;
        $display("FAIL %s/R2 ready after %0d clocks: got %b exp %b", phase_tag, m_clks, ready_o, m_ready);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired: got %0d cycles exp <= %0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int n = 0; n < SEQ_LEN; n++)
      seq[n] = (n < 11) ? 1'b1 : (seq[n - 11] ^ seq[n - 9]);
    checking = 1;

    phase_tag = "R1";
    rst_n = 0;
    tick(3);
    rst_n = 1;

    phase_tag = "R3";
    chip_en_i = 1; resync_i = 1;
    tick(6);
    resync_i = 0;

    phase_tag = "R4";
    tick(WALK - 12);
    // Resync held across the edge where ready rises.
    phase_tag = "R2";
    resync_i = 1;
    tick(8);
    resync_i = 0;

    phase_tag = "R7";
    tick(2 * SL + 20);

    phase_tag = "R8";
    for (int i = 0; i < 3 * SL; i++) begin
      chip_en_i = (i % 3 == 0) || (i > 2 * SL && i % 7 == 1);
      tick(1);
    end
    chip_en_i = 0;
    tick(20);

    phase_tag = "R6";
    resync_i = 1;
    tick(1);
    resync_i = 0;
    tick(5);
    chip_en_i = 1;
    tick(123);
    resync_i = 1; chip_en_i = 0;
    tick(3);
    resync_i = 0; chip_en_i = 1;

    phase_tag = "R10";
    while (m_idx != SL - 1) tick(1);
    resync_i = 1;
    tick(1);
    resync_i = 0;
    tick(SL + 5);

    phase_tag = "R1";
    rst_n = 0;
    tick(2);
    rst_n = 1;
    phase_tag = "R4";
    tick(WALK + 4);
    phase_tag = "R6";
    resync_i = 1;
    tick(1);
    resync_i = 0;
    tick(SL + 10);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule